// File: doc/BRIEF.md
# Single-Wire Dimming Command Receiver

This block listens on a shared single wire that rests high. The sender writes a command by toggling the wire. Each bit takes one low phase and then one high phase, and the ratio between the two phase lengths gives the bit's value. A command frame holds two bytes. The first byte carries a device address and the second byte carries a dimming setting. The receiver measures both phase lengths in system clock cycles and decides each bit. It then checks the whole frame and, only when the frame is good, loads a 5-bit dimming code.

The sender can ask for a reply. In that case the receiver answers by pulling the wire low for a fixed time after the frame ends, through an open-drain enable output. The stored code is also converted to a feedback reference level in millivolts. The conversion follows a curve whose step size grows as the code rises, and the result goes to the rest of the converter controller. A separate enable input, driven by the mode-selection logic, gates the whole receiver.

Top module: `swire_cmd_rx`

## Requirements
- R1: After reset the dimming code is 31, the level output reads 200, and both the pull-down enable and the frame strobe are low.
- R2: A frame is only recognised when the wire has been high for at least START_CYC cycles before the falling edge that opens it. If the wire falls after a shorter high time, no frame is started, and the bits that follow are ignored until a valid start is seen.
- R3: Each bit is one low phase followed by one high phase, and it is decided on the falling edge that ends the high phase. The bit is 1 when the high count exceeds twice the low count. It is 0 when the low count exceeds twice the high count. Any other ratio spoils the frame.
- R4: The frame carries 16 bits, most significant bit first. The first byte is an address and must equal 8'b0111_0010 (0x72). Any other address discards the frame.
- R5: In the second byte, bits 6 and 5 must both be 0. If either is 1, the frame is discarded.
- R6: The frame must end after exactly 16 bits. A frame with fewer or more bits is discarded.
- R7: A frame ends when the wire stays low for END_CYC cycles. The cycle after that, a good frame loads bits 4..0 of the second byte into the code and pulses frame_ok_o for exactly one cycle. A discarded frame leaves the code unchanged and gives no pulse.
- R8: When bit 7 of the second byte is 1 in a good frame, line_pd_o rises ACK_DLY_CYC cycles after the frame_ok_o pulse and stays high for ACK_LEN_CYC cycles. When bit 7 is 0, line_pd_o stays low.
- R9: The level output depends on the code as follows: code 0 gives 0 mV and code 1 gives 5 mV. Above code 1 the level grows by 3 mV per code up to 38 at code 12, then by 6 mV per code up to 104 at code 23, then by 12 mV per code up to 200 at code 31.
- R10: While dig_en_i is low, frames are not decoded, no code is loaded, any acknowledge in progress is cut off, and line_pd_o is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Wire level, already synchronised to clk |
| dig_en_i | input | 1 | Enables command decoding |
| line_pd_o | output | 1 | Open-drain pull-down enable for the acknowledge |
| dim_code_o | output | 5 | Stored dimming code |
| fb_mv_o | output | LVL_W | Feedback reference level in mV |
| frame_ok_o | output | 1 | One-cycle pulse when a good frame has been taken |

## Verification
The assertions hold on every cycle for the following properties:
- the pull-down is released one cycle after the enable drops;
- the frame strobe never lasts longer than a single cycle;
- the code changes only together with a strobe;
- the level rises whenever the code rises;
- the pull-down and the strobe are never high at the same time.

Only the bench scenarios can show the rest: the bit ratio decisions, how a frame is framed by the start and end conditions, the rejection of a wrong address, of reserved bits or of a wrong bit count, and the exact acknowledge delay and width. These are checked against frames that the bench builds and scores.

// File: rtl/swire_pkg.sv
package swire_pkg;
    localparam int CODE_W      = 5;
    localparam int FRAME_BITS  = 16;
    localparam int NBITS_W     = $clog2(FRAME_BITS + 1);
    localparam logic [7:0] DEV_ADDR = 8'h72;
    localparam logic [CODE_W-1:0] CODE_RST = 5'd31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DRIVE = 2'd3
    } rx_state_e;
endpackage

// File: rtl/swire_run_timer.sv
module swire_run_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             lvl_o,
    output logic [CNT_W-1:0] run_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] run;
    } run_t;

    run_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.lvl = line_i;
        if (line_i != r_q.lvl) begin
            r_d.run = CNT_W'(1);
        end else if (r_q.run != '1) begin
            r_d.run = r_q.run + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{lvl: 1'b1, run: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl_o  = r_q.lvl;
    assign run_o  = r_q.run;
    assign rise_o = !r_q.lvl && line_i;
    assign fall_o = r_q.lvl && !line_i;
endmodule

// File: rtl/swire_ratio_judge.sv
module swire_ratio_judge #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             one_o,
    output logic             zero_o
);
    always_comb begin
        one_o  = {1'b0, hi_i} > {lo_i, 1'b0};
        zero_o = {1'b0, lo_i} > {hi_i, 1'b0};
    end
endmodule

// File: rtl/swire_level_map.sv
module swire_level_map #(
    parameter int LVL_W = 8
) (
    input  logic [swire_pkg::CODE_W-1:0] code_i,
    output logic [LVL_W-1:0]             mv_o
);
    int c;
    int mv;

    always_comb begin
        c = int'(code_i);
        if (c == 0) begin
            mv = 0;
        end else if (c <= 12) begin
            mv = 3 * c + 2;
        end else if (c <= 23) begin
            mv = 6 * c - 34;
        end else begin
            mv = 12 * c - 172;
        end
        mv_o = LVL_W'(mv);
    end
endmodule

// File: rtl/swire_cmd_rx.sv
module swire_cmd_rx #(
    parameter int CNT_W       = 16,
    parameter int START_CYC   = 100,
    parameter int END_CYC     = 18000,
    parameter int ACK_DLY_CYC = 100,
    parameter int ACK_LEN_CYC = 25600,
    parameter int LVL_W       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         line_i,
    input  logic                         dig_en_i,
    output logic                         line_pd_o,
    output logic [swire_pkg::CODE_W-1:0] dim_code_o,
    output logic [LVL_W-1:0]             fb_mv_o,
    output logic                         frame_ok_o
);
    import swire_pkg::*;

    localparam int TMR_MAX = (ACK_DLY_CYC > ACK_LEN_CYC) ? ACK_DLY_CYC : ACK_LEN_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        rx_state_e              state;
        logic [TMR_W-1:0]       tmr;
        logic [CNT_W-1:0]       lo_len;
        logic [FRAME_BITS-1:0]  shreg;
        logic [NBITS_W-1:0]     nbits;
        logic                   err;
        logic [CODE_W-1:0]      code;
        logic                   ok;
    } rx_t;

    rx_t s_d, s_q;

    logic             lvl_q;
    logic [CNT_W-1:0] run_q;
    logic             rise, fall;
    logic             is_one, is_zero;
    logic             frame_good;

    swire_run_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .lvl_o  (lvl_q),
        .run_o  (run_q),
        .rise_o (rise),
        .fall_o (fall)
    );

    swire_ratio_judge #(.CNT_W(CNT_W)) u_judge (
        .hi_i   (run_q),
        .lo_i   (s_q.lo_len),
        .one_o  (is_one),
        .zero_o (is_zero)
    );

    swire_level_map #(.LVL_W(LVL_W)) u_map (
        .code_i (s_q.code),
        .mv_o   (fb_mv_o)
    );

    assign frame_good = !s_q.err
                     && (s_q.nbits == NBITS_W'(FRAME_BITS))
                     && (s_q.shreg[15:8] == DEV_ADDR)
                     && (s_q.shreg[6:5] == 2'b00);

    always_comb begin
        s_d    = s_q;
        s_d.ok = 1'b0;
        if (!dig_en_i) begin
            s_d.state = ST_IDLE;
            s_d.tmr   = '0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (fall && (run_q >= CNT_W'(START_CYC))) begin
                        s_d.state  = ST_RECV;
                        s_d.nbits  = '0;
                        s_d.err    = 1'b0;
                        s_d.lo_len = '0;
                    end
                end
                ST_RECV: begin
                    if (rise) begin
                        s_d.lo_len = run_q;
                    end
                    if (fall) begin
                        if (s_q.nbits == NBITS_W'(FRAME_BITS)) begin
                            s_d.err = 1'b1;
                        end else begin
                            s_d.nbits = s_q.nbits + NBITS_W'(1);
                            s_d.shreg = {s_q.shreg[FRAME_BITS-2:0], is_one};
                            if (!(is_one || is_zero)) begin
                                s_d.err = 1'b1;
                            end
                        end
                    end
                    if (!lvl_q && (run_q >= CNT_W'(END_CYC))) begin
                        s_d.state = ST_IDLE;
                        if (frame_good) begin
                            s_d.code = s_q.shreg[CODE_W-1:0];
                            s_d.ok   = 1'b1;
                            if (s_q.shreg[7]) begin
                                s_d.state = ST_WAIT;
                                s_d.tmr   = '0;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (s_q.tmr == TMR_W'(ACK_DLY_CYC - 1)) begin
                        s_d.state = ST_DRIVE;
                        s_d.tmr   = '0;
                    end else begin
                        s_d.tmr = s_q.tmr + TMR_W'(1);
                    end
                end
                ST_DRIVE: begin
                    if (s_q.tmr == TMR_W'(ACK_LEN_CYC - 1)) begin
                        s_d.state = ST_IDLE;
                        s_d.tmr   = '0;
                    end else begin
                        s_d.tmr = s_q.tmr + TMR_W'(1);
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, tmr: '0, lo_len: '0, shreg: '0,
                     nbits: '0, err: 1'b0, code: CODE_RST, ok: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign line_pd_o  = (s_q.state == ST_DRIVE);
    assign dim_code_o = s_q.code;
    assign frame_ok_o = s_q.ok;
endmodule

// File: rtl/swire_cmd_rx_chk.sv
module swire_cmd_rx_chk #(
    parameter int LVL_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         dig_en_i,
    input logic                         line_pd_o,
    input logic [swire_pkg::CODE_W-1:0] dim_code_o,
    input logic [LVL_W-1:0]             fb_mv_o,
    input logic                         frame_ok_o
);
    // R10
    pd_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_en_i |=> !line_pd_o);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok_o |=> !frame_ok_o);

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dim_code_o) |-> frame_ok_o);

    // R9
    level_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_code_o > $past(dim_code_o)) |-> (fb_mv_o > $past(fb_mv_o)));

    // R8
    pd_not_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_pd_o |-> !frame_ok_o);
endmodule

bind swire_cmd_rx swire_cmd_rx_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dig_en_i   (dig_en_i),
    .line_pd_o  (line_pd_o),
    .dim_code_o (dim_code_o),
    .fb_mv_o    (fb_mv_o),
    .frame_ok_o (frame_ok_o)
);

// File: tb/swire_cmd_rx_bench.sv
module swire_cmd_rx_bench;
    localparam int CNT_W = 10;
    localparam int START = 8;
    localparam int ENDC  = 64;
    localparam int ADLY  = 4;
    localparam int ALEN  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv = 1'b1;
    logic dig_en = 1'b1;
    logic line_pd;
    logic [4:0] code;
    logic [7:0] mv;
    logic frame_ok;
    logic line_w;

    assign line_w = drv & ~line_pd;

    always #10 clk = ~clk;

    swire_cmd_rx #(
        .CNT_W(CNT_W), .START_CYC(START), .END_CYC(ENDC),
        .ACK_DLY_CYC(ADLY), .ACK_LEN_CYC(ALEN), .LVL_W(8)
    ) u_swire_cmd_rx (
        .clk(clk), .rst_n(rst_n), .line_i(line_w), .dig_en_i(dig_en),
        .line_pd_o(line_pd), .dim_code_o(code), .fb_mv_o(mv), .frame_ok_o(frame_ok)
    );

    int compared = 0;
    int mismatched = 0;
    int exp_q[$];
    int acks = 0;
    int exp_acks = 0;
    int cur = 31;
    int cyc = 0;
    int t_strobe = 0;
    int pd_w = 0;
    logic pd_prev = 1'b0;
    bit done = 0;

    function automatic int model_mv(input int c);
        int l = 0;
        for (int k = 1; k <= c; k++) begin
            if (k == 1) l += 5;
            else if (k <= 12) l += 3;
            else if (k <= 23) l += 6;
            else l += 12;
        end
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        drv = v;
        repeat (n) @(negedge clk);
    endtask

    // 17-bit word: bits are sent from w[16] downward, nb of them
    task automatic send(input logic [16:0] w, input int nb, input int st_len, input int bad_at);
        hold(1'b1, st_len);
        for (int i = 0; i < nb; i++) begin
            if (i == bad_at) begin
                hold(1'b0, 8); hold(1'b1, 8);
            end else if (w[16-i]) begin
                hold(1'b0, 2); hold(1'b1, 7);
            end else begin
                hold(1'b0, 15); hold(1'b1, 5);
            end
        end
        hold(1'b0, ENDC + 3);
        hold(1'b1, ADLY + ALEN + 20);
    endtask

    task automatic good(input int c, input bit ack, input string req);
        exp_q.push_back(c);
        if (ack) exp_acks++;
        send({8'h72, ack, 2'b00, 5'(c), 1'b0}, 16, 20, -1);
        cur = c;
        chk(code == 5'(c), req, code, c);
        chk(acks == exp_acks, "R8", acks, exp_acks);
    endtask

    task automatic reject(input string req);
        chk(code == 5'(cur), req, code, cur);
        chk(acks == exp_acks, req, acks, exp_acks);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (frame_ok) begin
                t_strobe = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", code, cur);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(code == 5'(e), "R7", code, e);
                    chk(int'(mv) == model_mv(e), "R9", mv, model_mv(e));
                end
            end
            if (line_pd && !pd_prev) begin
                acks++;
                pd_w = 1;
                chk(cyc - t_strobe == ADLY, "R8", cyc - t_strobe, ADLY);
            end else if (line_pd) begin
                pd_w++;
            end else if (pd_prev) begin
                chk(pd_w == ALEN, "R8", pd_w, ALEN);
            end
            pd_prev = line_pd;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(code == 5'd31, "R1", code, 31);
        chk(mv == 8'd200, "R1", mv, 200);
        chk(line_pd == 1'b0, "R1", line_pd, 0);
        chk(frame_ok == 1'b0, "R1", frame_ok, 0);
        hold(1'b1, 20);

        // R3 R4 R7 plain frame, no acknowledge
        good(13, 1'b0, "R7");
        // R8 frame with acknowledge
        good(0, 1'b1, "R8");
        // R4 wrong address
        send({8'h73, 8'h07, 1'b0}, 16, 20, -1);
        reject("R4");
        // R5 reserved bit 6 set
        send({8'h72, 8'h47, 1'b0}, 16, 20, -1);
        reject("R5");
        // R5 reserved bit 5 set
        send({8'h72, 8'h27, 1'b0}, 16, 20, -1);
        reject("R5");
        // R2 start too short after a low period
        hold(1'b0, 10);
        send({8'h72, 8'h09, 1'b0}, 16, 3, -1);
        reject("R2");
        // R3 bit with equal phases
        send({8'h72, 8'h09, 1'b0}, 16, 20, 10);
        reject("R3");
        // R6 too few bits
        send({8'h72, 8'h09, 1'b0}, 15, 20, -1);
        reject("R6");
        // R6 too many bits
        send({8'h72, 8'h09, 1'b0}, 17, 20, -1);
        reject("R6");
        // R10 disabled: nothing decoded, no acknowledge
        dig_en = 1'b0;
        send({8'h72, 8'h89, 1'b0}, 16, 20, -1);
        reject("R10");
        chk(line_pd == 1'b0, "R10", line_pd, 0);
        dig_en = 1'b1;
        hold(1'b1, 20);
        // R9 level curve at the knees
        good(1, 1'b0, "R9");
        good(12, 1'b0, "R9");
        good(23, 1'b1, "R9");
        good(24, 1'b0, "R9");
        good(31, 1'b0, "R9");
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
        finish_run();
    end
endmodule